// File: doc/BRIEF.md
# Two-Channel Interleaved Second-Order-Lag Recursive Filter

This block runs one recursive filter, y(n) = x(n) + a·y(n−2), for two independent audio channels through a single multiplier and a single adder. Every state delay of the one-channel filter is doubled, so the feedback loop holds four registers instead of two. Samples of channel 0 and channel 1 therefore enter in strict alternation, and each channel only ever meets its own history. One of the four loop registers sits directly after the multiplier, so the adder does not wait on the product in the same cycle.

The source presents a signed 16-bit sample with a one-bit channel tag and a valid strobe. One cycle later the filtered sample leaves, widened by one guard bit and clamped at the 17-bit signed limits, together with the tag it came in with. Cycles without valid input freeze the filter state. The coefficient is a signed fixed-point parameter with 14 fraction bits. Its default, 12288, stands for 0.75.

Top module: `stereo_slow2_iir`

## Requirements
- R1: Reset (synchronous, active high) clears all filter state and drives out_valid to 0 and out_sample to 0. The first two samples of each channel after reset therefore come out as the clamped input alone.
- R2: For every cycle with in_valid high, out_valid is high in the next cycle and out_chan equals that cycle's in_chan. A cycle with in_valid low gives out_valid low in the next cycle.
- R3: For each channel, the output for sample n is clamp(x(n) + floor(y(n−2)·COEF / 2^14)), where y(n−2) is that channel's clamped output two of its own samples earlier and COEF is the signed coefficient.
- R4: The two channels are independent. No value on channel 1 changes any output of channel 0, and no value on channel 0 changes any output of channel 1.
- R5: Results above 65535 leave as 65535 and results below −65536 leave as −65536. The clamped value is also the one held as feedback state.
- R6: Cycles with in_valid low do not advance the filter. out_sample keeps its last value, and the results of later samples are the same as if the idle cycles had not occurred.
- R7: After reset the first valid sample carries tag 0, and each following valid sample carries the opposite tag of the valid sample before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_chan | input | 1 | Channel tag of the input sample (0 or 1) |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present this cycle |
| out_chan | output | 1 | Channel tag of the output sample |
| out_sample | output | 17 | Signed clamped filter output |

## Verification
A slip of one position in the four-register loop makes a channel read the other channel's history, or its own history from the wrong distance. Because of the zero tap at lag one, an impulse on one channel then shows up as a wrong nonzero value, or a missing one, at that channel's second output, or as a leak into the other channel within four samples. A feedback register that is not cleared or not clamped shows at the first output after reset, or at the first sample past the limit, through a wrong value of out_sample. A wrong tag or a lost valid shows in the cycle after the sample is presented.

// File: rtl/slow2_iir_pkg.sv
package slow2_iir_pkg;

    localparam int DATA_W    = 16;
    localparam int GUARD_W   = 1;
    localparam int OUT_W     = DATA_W + GUARD_W;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int SLOW_K    = 2;
    localparam int PROD_W    = OUT_W + COEF_W;
    localparam int SUM_W     = PROD_W - COEF_FRAC + 1;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [OUT_W-1:0]  ystate_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    localparam coef_t DEF_COEF = 16'sd12288;

    localparam sum_t SUM_MAX = sum_t'((2 ** (OUT_W - 1)) - 1);
    localparam sum_t SUM_MIN = -sum_t'(2 ** (OUT_W - 1));

    typedef struct packed {
        logic valid;
        logic chan;
    } tag_t;

    function automatic ystate_t clamp_y(input sum_t s);
        if (s > SUM_MAX)
            return ystate_t'(SUM_MAX);
        else if (s < SUM_MIN)
            return ystate_t'(SUM_MIN);
        else
            return ystate_t'(s);
    endfunction

endpackage

// File: rtl/slow2_iir_scale.sv
module slow2_iir_scale
    import slow2_iir_pkg::*;
#(
    parameter coef_t COEF = DEF_COEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  ystate_t y_in,
    output sum_t    scaled_q
);
    logic signed [PROD_W-1:0] y_ext;
    logic signed [PROD_W-1:0] c_ext;
    logic signed [PROD_W-1:0] prod;
    sum_t                     scaled;

    always_comb begin
        y_ext  = PROD_W'(y_in);
        c_ext  = PROD_W'(COEF);
        prod   = y_ext * c_ext;
        scaled = sum_t'(prod >>> COEF_FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst)
            scaled_q <= '0;
        else if (en)
            scaled_q <= scaled;
    end
endmodule

// File: rtl/slow2_iir_delay.sv
module slow2_iir_delay
    import slow2_iir_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  ystate_t d_in,
    output ystate_t taps [DEPTH]
);
    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    taps[i] <= '0;
                else if (en) begin
                    if (i == 0)
                        taps[i] <= d_in;
                    else
                        taps[i] <= taps[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/slow2_iir_sat_add.sv
module slow2_iir_sat_add
    import slow2_iir_pkg::*;
(
    input  sample_t x_in,
    input  sum_t    fb_in,
    output ystate_t y_out
);
    sum_t total;

    always_comb begin
        total = sum_t'(x_in) + fb_in;
        y_out = clamp_y(total);
    end
endmodule

// File: rtl/stereo_slow2_iir.sv
module stereo_slow2_iir
    import slow2_iir_pkg::*;
#(
    parameter coef_t COEF = DEF_COEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_chan,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic                     out_chan,
    output logic signed [OUT_W-1:0]  out_sample
);
    // Loop registers: the per-channel lag of two becomes SLOW_K*2 beats;
    // one of them is the product register, the rest form the output chain.
    localparam int LOOP_REGS = SLOW_K * 2;
    localparam int CHAIN_LEN = LOOP_REGS - 1;

    ystate_t y_next;
    ystate_t taps [CHAIN_LEN];
    sum_t    fb_q;
    tag_t    tag_q;

    slow2_iir_sat_add u_add (
        .x_in  (in_sample),
        .fb_in (fb_q),
        .y_out (y_next)
    );

    slow2_iir_delay #(.DEPTH(CHAIN_LEN)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .d_in (y_next),
        .taps (taps)
    );

    slow2_iir_scale #(.COEF(COEF)) u_scale (
        .clk      (clk),
        .rst      (rst),
        .en       (in_valid),
        .y_in     (taps[CHAIN_LEN-1]),
        .scaled_q (fb_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tag_q <= '0;
        else begin
            tag_q.valid <= in_valid;
            if (in_valid)
                tag_q.chan <= in_chan;
        end
    end

    assign out_valid  = tag_q.valid;
    assign out_chan   = tag_q.chan;
    assign out_sample = taps[0];
endmodule

// File: rtl/slow2_iir_chk.sv
module slow2_iir_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_chan,
    input logic        out_valid,
    input logic        out_chan,
    input logic [16:0] out_sample
);
    logic seen_q;
    logic last_chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q      <= 1'b0;
            last_chan_q <= 1'b0;
        end else if (in_valid) begin
            seen_q      <= 1'b1;
            last_chan_q <= in_chan;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_chan == $past(in_chan)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    // R7
    first_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !seen_q) |-> !in_chan);

    // R7
    alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen_q) |-> (in_chan != last_chan_q));
endmodule

bind stereo_slow2_iir slow2_iir_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_sample (out_sample)
);

// File: tb/stereo_slow2_iir_bench.sv
module stereo_slow2_iir_bench;

    localparam longint COEF_V = 12288;
    localparam longint Y_MAX  = 65535;
    localparam longint Y_MIN  = -65536;

    typedef struct {
        bit     ch;
        longint val;
        string  req;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_chan = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic               out_chan;
    logic signed [16:0] out_sample;

    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    exp_t   sb [$];
    longint hist [2][2];
    bit     next_ch = 1'b0;
    longint last_out = 0;
    logic [15:0] lfsr = 16'hACE1;

    stereo_slow2_iir u_stereo_slow2_iir (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_chan    (in_chan),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_sample (out_sample)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint model_step(input bit ch, input longint x);
        longint fb;
        longint y;
        fb = (hist[ch][1] * COEF_V) >>> 14;
        y  = x + fb;
        if (y > Y_MAX) y = Y_MAX;
        if (y < Y_MIN) y = Y_MIN;
        hist[ch][1] = hist[ch][0];
        hist[ch][0] = y;
        return y;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 2; k++)
                hist[c][k] = 0;
        next_ch = 1'b0;
    endtask

    task automatic send(input longint x, input string req);
        exp_t e;
        e.ch  = next_ch;
        e.val = model_step(next_ch, x);
        e.req = req;
        sb.push_back(e);
        in_valid  = 1'b1;
        in_chan   = next_ch;
        in_sample = 16'(x);
        next_ch   = ~next_ch;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        idle(3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        // R1: state after reset, seen at the ports
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(out_sample == '0, "R1", longint'(out_sample), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard as results appear
    always @(posedge clk) begin
        #1;
        if (rst) begin
            last_out = 0;
        end else if (out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", longint'(out_valid), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_chan == e.ch, "R2", longint'(out_chan), longint'(e.ch));
                check(longint'(out_sample) == e.val, e.req, longint'(out_sample), e.val);
            end
            last_out = longint'(out_sample);
        end else begin
            // R6: idle cycle leaves the output untouched
            check(longint'(out_sample) == last_out, "R6", longint'(out_sample), last_out);
        end
    end

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 after power-up reset
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(out_sample == '0, "R1", longint'(out_sample), 0);

        // R1/R3: impulse on channel 0, silence on channel 1
        send(1000, "R1");
        send(0, "R1");
        for (int i = 0; i < 10; i++) begin
            send(0, "R3");
            send(0, "R3");
        end

        // R3: negative step on channel 1
        for (int i = 0; i < 12; i++) begin
            send(0, "R3");
            send(-2000, "R3");
        end

        // R4: channel 0 impulse with loud alternating noise on channel 1
        do_reset();
        send(4096, "R4");
        send(30000, "R4");
        for (int i = 0; i < 10; i++) begin
            send(0, "R4");
            send((i % 2 == 0) ? -32768 : 32767, "R4");
        end

        // R5: sustained extremes drive both channels into the limits
        do_reset();
        for (int i = 0; i < 24; i++) begin
            send(32767, "R5");
            send(-32768, "R5");
        end
        for (int i = 0; i < 6; i++) begin
            send(-32768, "R5");
            send(32767, "R5");
        end
        check(hist[0][0] == Y_MIN || hist[0][0] > Y_MIN, "R5", hist[0][0], Y_MIN);

        // R6: idle gaps between samples
        do_reset();
        for (int i = 0; i < 16; i++) begin
            send(longint'(i * 700) - 5000, "R6");
            idle((i % 3) + 1);
        end

        // R3: pseudo-random stream, back to back
        do_reset();
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(longint'($signed(lfsr)), "R3");
            if (i % 37 == 36) idle(2);
        end

        // R7: restart after a reset mid-stream begins again with channel 0
        send(123, "R7");
        do_reset();
        send(-321, "R7");
        send(321, "R7");
        send(0, "R7");
        send(0, "R7");

        idle(4);
        check(sb.size() == 0, "R2", longint'(sb.size()), 0);
        finish_run();
    end
endmodule